// File: doc/BRIEF.md
# Prescaled Compare-Match Up-Timer

This block is a programmable interval timer. It has an 8-bit prescaler that divides the input clock, followed by a 24-bit up-counter. When the counter equals a programmed compare value, a match event occurs. A small word-addressed register port lets software program the divider, the compare value, the operating mode and the enables. The same port reads back a shadow copy of the counter and a sticky interrupt flag.

There are three operating modes. One-shot mode produces a single match, after which the block clears its own run enable. Periodic mode produces a match every (compare+1)×(prescale+1) input clocks. Toggle mode behaves like periodic mode and also inverts a square-wave output on each match, so the output has a 50% duty cycle.

A soft reset bit restarts the prescaler and the counter in one write. Clearing the enable pauses the count, and setting it again continues from the held value.

Top module: `prescaled_match_timer`

## Requirements
- R1: After `rstN` is released, every register reads 0 and both `irq` and `tout` are low.
- R2: While the timer runs, the counter advances once every (prescale+1) clocks. The prescale value is the 8-bit field at bits 7:0 of the control word (address 0). A value of 0 advances the counter on every clock.
- R3: In periodic mode (mode field 01) and toggle mode (10), a prescaled tick that finds the counter equal to the compare register (address 1, bits 23:0) is a match. That tick returns the counter to 0.
- R4: A match sets the sticky flag (address 3, bit 0) only while interrupt enable (control bit 29) is 1. `irq` follows the flag. Writing 1 to flag bit 0 clears it. When interrupt enable is 0, a match leaves the flag at 0.
- R5: In one-shot mode (mode field at bits 28:27 equal to 00), a match returns the counter to 0 and clears the run enable (control bit 30). Counting then stops.
- R6: In toggle mode, `tout` inverts on every match. In the other modes `tout` does not change.
- R7: Writing control bit 26 as 1 clears the prescaler, the counter, the run enable and `tout` in that same write. Bit 26 reads 1 for the one cycle after the write and then reads 0.
- R8: Clearing the run enable freezes both the prescaler and the counter. Setting it again continues counting from the frozen values.
- R9: While data-load enable (control bit 16) is 1, the data register (address 2) takes the counter value each clock, one cycle behind it. While the bit is 0, the data register holds its value.
- R10: Control bit 25 is read-only and reads 1 exactly when the run enable is set and the mode is not 11. Mode 11 keeps the counter stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address: 0 control, 1 compare, 2 data, 3 flag |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Level interrupt request |
| tout | output | 1 | Square-wave output in toggle mode |

## Verification
The bench builds the block with its default widths: an 8-bit prescaler and a 24-bit counter. It keeps the programmed values small so that many wraps fit into a short run. It sweeps prescale values 0 to 3 and compare values 0 to 4, in both periodic and toggle mode. For each pair it computes the counter value, the match count and the `tout` parity arithmetically from the number of enabled clocks. It then repeats the calculation after a pause and resume. The first match is pinned to its exact clock. Separate sequences cover one-shot mode, the reserved mode, gating of the data register and the pulse of the soft reset bit.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int DATA_W     = 32;
  localparam int BIT_LOADEN = 16;
  localparam int BIT_ACTIVE = 25;
  localparam int BIT_SRST   = 26;
  localparam int MODE_LO    = 27;
  localparam int BIT_IE     = 29;
  localparam int BIT_EN     = 30;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_TOGGLE   = 2'b10,
    MODE_RSVD     = 2'b11
  } timerMode_t;

  typedef struct packed {
    logic run;
    logic clr;
    logic toggleMode;
    logic loadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] compare,
  output logic             matchEvent,
  output logic [CNT_W-1:0] tdrVal,
  output logic             tout
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt;
  logic             preTick;

  assign preTick    = strb.run && (preCnt >= prescale);
  assign matchEvent = preTick && (cnt == compare);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
      tout   <= 1'b0;
    end else if (strb.clr) begin
      preCnt <= '0;
      cnt    <= '0;
      tout   <= 1'b0;
    end else if (strb.run) begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (preTick) cnt <= matchEvent ? '0 : cnt + 1'b1;
      if (matchEvent && strb.toggleMode) tout <= ~tout;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tdrVal <= '0;
    else if (strb.loadEn) tdrVal <= cnt;
  end

  p_clear_zeroes_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0) && (preCnt == '0) && !tout);

  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clr) |=> ($stable(cnt) && $stable(preCnt)));

  p_wrap_on_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && !strb.clr) |=> (cnt == '0));

  p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && strb.toggleMode && !strb.clr) |=> (tout != $past(tout)));
endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              matchEvent,
  input  logic [CNT_W-1:0]  tdrVal,
  output ctrlStrobes_t      strb,
  output logic [PRE_W-1:0]  prescale,
  output logic [CNT_W-1:0]  compare,
  output logic              irq,
  output logic [DATA_W-1:0] regRdata
);
  timerMode_t mode;
  logic loadEn, intEn, enable, srstBit, flag, active;
  logic ctrlWr, cmpWr, flagClr;
  logic unusedWdata;

  assign unusedWdata = ^regWdata;
  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign cmpWr   = regWe && (regAddr == ADDR_CMP);
  assign flagClr = regWe && (regAddr == ADDR_FLAG) && regWdata[0];
  assign active  = enable && (mode != MODE_RSVD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
      loadEn   <= 1'b0;
      mode     <= MODE_ONESHOT;
      intEn    <= 1'b0;
      enable   <= 1'b0;
      srstBit  <= 1'b0;
      compare  <= '0;
      flag     <= 1'b0;
    end else begin
      srstBit <= ctrlWr && regWdata[BIT_SRST];
      if (ctrlWr) begin
        prescale <= regWdata[PRE_W-1:0];
        loadEn   <= regWdata[BIT_LOADEN];
        mode     <= timerMode_t'(regWdata[MODE_LO+1:MODE_LO]);
        intEn    <= regWdata[BIT_IE];
        enable   <= regWdata[BIT_EN] && !regWdata[BIT_SRST];
      end else if (matchEvent && (mode == MODE_ONESHOT)) begin
        enable <= 1'b0;
      end
      if (cmpWr) compare <= regWdata[CNT_W-1:0];
      if (matchEvent && intEn) flag <= 1'b1;
      else if (flagClr)        flag <= 1'b0;
    end
  end

  always_comb begin
    strb.run        = active;
    strb.clr        = ctrlWr && regWdata[BIT_SRST];
    strb.toggleMode = (mode == MODE_TOGGLE);
    strb.loadEn     = loadEn;
  end

  assign irq = flag;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[PRE_W-1:0]          = prescale;
        regRdata[BIT_LOADEN]         = loadEn;
        regRdata[BIT_ACTIVE]         = active;
        regRdata[BIT_SRST]           = srstBit;
        regRdata[MODE_LO+1:MODE_LO]  = mode;
        regRdata[BIT_IE]             = intEn;
        regRdata[BIT_EN]             = enable;
      end
      ADDR_CMP:  regRdata[CNT_W-1:0] = compare;
      ADDR_DATA: regRdata[CNT_W-1:0] = tdrVal;
      default:   regRdata[0]         = flag;
    endcase
  end

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && (mode == MODE_ONESHOT) && !ctrlWr) |=> !enable);

  p_flag_on_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvent && intEn) |=> irq);

  p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RSVD) |-> !matchEvent);
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import pmt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        tout
);
  ctrlStrobes_t     strb;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] compare;
  logic [CNT_W-1:0] tdrVal;
  logic             matchEvent;

  pmt_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .matchEvent(matchEvent), .tdrVal(tdrVal),
    .strb(strb), .prescale(prescale), .compare(compare), .irq(irq),
    .regRdata(regRdata)
  );

  pmt_datapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .prescale(prescale),
    .compare(compare), .matchEvent(matchEvent), .tdrVal(tdrVal), .tout(tout)
  );
endmodule

// File: tb/tb_prescaled_match_timer.sv
`timescale 1ns/1ps
module tb_prescaled_match_timer;
  localparam logic [31:0] EN  = 32'h1 << 30;
  localparam logic [31:0] IE  = 32'h1 << 29;
  localparam logic [31:0] SR  = 32'h1 << 26;
  localparam logic [31:0] LD  = 32'h1 << 16;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq, tout;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  prescaled_match_timer dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .tout(tout)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d, ctrl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R1 register", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tout", {31'b0, tout}, 0);

    // R2 R3 R4 R6 R8 sweep over mode, prescale and compare
    for (int md = 1; md <= 2; md++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 5; c++) begin
          int k, k2, ticks, m;
          wr(2'd0, SR); wr(2'd1, c); wr(2'd3, 1);
          ctrl = EN | IE | (md << 27) | LD | p;
          wr(2'd0, ctrl);
          k = 20 + 3 * p + c;
          repeat (k - 1) @(negedge clk);
          wr(2'd0, ctrl & ~EN);
          repeat (2) @(negedge clk);
          ticks = k / (p + 1); m = ticks / (c + 1);
          rd(2'd2, d); chk("R2 R3 count", d, ticks % (c + 1));
          chk("R4 irq", {31'b0, irq}, (m > 0) ? 1 : 0);
          chk("R6 tout", {31'b0, tout}, (md == 2) ? (m & 1) : 0);
          k2 = 7 + p;
          wr(2'd0, ctrl);
          repeat (k2 - 1) @(negedge clk);
          wr(2'd0, ctrl & ~EN);
          repeat (2) @(negedge clk);
          ticks = (k + k2) / (p + 1); m = ticks / (c + 1);
          rd(2'd2, d); chk("R8 resume count", d, ticks % (c + 1));
          chk("R6 tout after resume", {31'b0, tout}, (md == 2) ? (m & 1) : 0);
          wr(2'd3, 1);
          chk("R4 clear", {31'b0, irq}, 0);
        end

    // R4 exact first match cycle: prescale 2, compare 3
    wr(2'd0, SR); wr(2'd1, 3); wr(2'd3, 1);
    wr(2'd0, EN | IE | (1 << 27) | LD | 2);
    repeat (11) @(negedge clk);
    chk("R4 before match", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R4 at match", {31'b0, irq}, 1);

    // R4 no flag with interrupt enable off
    wr(2'd0, SR); wr(2'd3, 1); wr(2'd1, 0);
    wr(2'd0, EN | (1 << 27) | LD);
    repeat (10) @(negedge clk);
    wr(2'd0, LD);
    rd(2'd3, d); chk("R4 ie off flag", d, 0);
    chk("R4 ie off irq", {31'b0, irq}, 0);

    // R5 one-shot
    wr(2'd0, SR); wr(2'd1, 2); wr(2'd3, 1);
    wr(2'd0, EN | IE | LD | 1);
    repeat (20) @(negedge clk);
    rd(2'd0, d);
    chk("R5 enable cleared", {31'b0, d[30]}, 0);
    chk("R10 inactive after one-shot", {31'b0, d[25]}, 0);
    chk("R5 irq", {31'b0, irq}, 1);
    rd(2'd2, d); chk("R5 counter zero", d, 0);

    // R9 data register gating
    wr(2'd0, SR); wr(2'd1, 100);
    wr(2'd0, EN | (1 << 27) | LD);
    repeat (4) @(negedge clk);
    wr(2'd0, EN | (1 << 27));
    repeat (9) @(negedge clk);
    wr(2'd0, (1 << 27));
    rd(2'd2, d); chk("R9 held", d, 4);
    wr(2'd0, LD);
    repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R9 tracking", d, 15);

    // R10 reserved mode
    wr(2'd0, SR);
    wr(2'd0, EN | (3 << 27) | LD);
    rd(2'd0, d); chk("R10 reserved inactive", {31'b0, d[25]}, 0);
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R10 reserved no count", d, 0);
    wr(2'd0, EN | (1 << 27) | LD);
    rd(2'd0, d); chk("R10 active", {31'b0, d[25]}, 1);
    repeat (5) @(negedge clk);

    // R7 soft reset pulse and clearing
    wr(2'd0, SR);
    rd(2'd0, d);
    chk("R7 bit reads 1", {31'b0, d[26]}, 1);
    chk("R7 enable cleared", {31'b0, d[30]}, 0);
    @(negedge clk);
    rd(2'd0, d); chk("R7 bit self-clears", {31'b0, d[26]}, 0);
    wr(2'd0, LD);
    repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R7 counter cleared", d, 0);

    summary();
  end
endmodule